// File: doc/BRIEF.md
# Symmetric Folded 16-Tap FIR Filter

This block is a fully parallel finite impulse response filter for a stream of unsigned 8-bit samples. Its sixteen taps carry coefficients that mirror about the centre, so the filter adds each pair of mirror-image samples first and multiplies each pair sum once. Eight constant multipliers are enough, and the block still accepts one sample and delivers one filtered result on every clock.

Samples arrive with a valid flag. Each accepted sample enters a sixteen-deep history, and the result for that sample leaves three register stages later with its own valid flag. The eight distinct coefficients and the number of low bits dropped from the full-precision sum are fixed by parameters when the block is elaborated.

Top module: `symfir_top`

## Requirements
- R1: The sample history holds the last 16 accepted samples, with the newest at tap 0. It advances by one position only on a clock where `in_valid` is high. Cycles with `in_valid` low leave the history unchanged, so gaps in the stream do not affect later results.
- R2: Coefficient c_k for k = 0..7 is taken from bits [8k+7:8k] of `COEF_VEC`. Taps k and 15-k share c_k. The default values for c0..c7 are 1, 2, 3, 4, 6, 8, 12 and 16.
- R3: `out_result` is floor(S / 2^DROP), where S = sum over k of c_k * (x[k] + x[15-k]) and DROP defaults to 5. With the default coefficients S never exceeds 10+DROP bits, and sixteen samples of 255 give 828.
- R4: A sample accepted on rising edge E produces its result after edge E+2, so the output register is the third register on the path. `out_valid` is high in exactly that cycle and is low whenever no sample was accepted three edges earlier.
- R5: Back-to-back valid samples produce back-to-back valid results, one per clock, with no stall.
- R6: A synchronous active-low reset clears the history, the intermediate stages and both valid flags. After reset `out_valid` and `out_result` are 0, and the first results depend only on samples accepted after reset.
- R7: Samples, coefficients and results are unsigned. A sample of 128 or above counts at its full magnitude and is not treated as negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_sample` in this cycle |
| in_sample | input | 8 | Unsigned input sample |
| out_valid | output | 1 | Qualifies `out_result` in this cycle |
| out_result | output | 10 | Filtered, scaled unsigned result |

## Verification
The hardest situation to reach from the ports is a result that depends on the history staying frozen. This happens when idle cycles, or a reset, fall while valid samples are still moving through the three stages. The bench reaches it with streams that mix random valid gaps with bursts, and with a reset asserted in the middle of a burst. An impulse is fed in afterwards, so every later result exposes any stale or shifted history. An impulse sweep over every sample value 0..255 brings out each coefficient times each magnitude, and a run of all-maximum samples hits the top of the result range.

// File: rtl/symfir_pkg.sv
// Shared constants and width helpers for the symmetric folded FIR.
// Assumes the tap count is even so every tap has a mirror partner.
package symfir_pkg;

    // Number of register stages from sample input to result output.
    localparam int PIPE_STAGES = 3;

    // Width of the full-precision sum of n products of pair_w x coef_w.
    function automatic int acc_width(input int pair_w, input int coef_w, input int n);
        return pair_w + coef_w + $clog2(n);
    endfunction

endpackage

// File: rtl/symfir_delay_line.sv
// Sample history: a chain of TAPS registers, index 0 newest.
// Shifts only when a valid sample is offered; also registers the valid flag
// so the following stage knows the history just changed.
module symfir_delay_line #(
    parameter int TAPS     = 16,
    parameter int SAMPLE_W = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               shift_en,
    input  logic [SAMPLE_W-1:0]                din,
    output logic [TAPS-1:0][SAMPLE_W-1:0]      line_q,
    output logic                               line_vld
);

    // Stage 0 takes the new sample; each later stage takes its neighbour.
    for (genvar t = 0; t < TAPS; t++) begin : g_stage
        if (t == 0) begin : g_head
            // Capture the incoming sample when it is valid.
            always_ff @(posedge clk) begin
                if (!rst_n)        line_q[t] <= '0;
                else if (shift_en) line_q[t] <= din;
            end
        end else begin : g_body
            // Move the previous tap's sample along on a valid cycle.
            always_ff @(posedge clk) begin
                if (!rst_n)        line_q[t] <= '0;
                else if (shift_en) line_q[t] <= line_q[t-1];
            end
        end
    end

    // Flag that the history was updated on this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) line_vld <= 1'b0;
        else        line_vld <= shift_en;
    end

endmodule

// File: rtl/symfir_preadd.sv
// Folding stage: adds each tap to its mirror tap and registers the sums.
// Assumes TAPS is even; each sum is one bit wider than a sample.
module symfir_preadd #(
    parameter int TAPS     = 16,
    parameter int SAMPLE_W = 8,
    localparam int HALF    = TAPS / 2,
    localparam int PAIR_W  = SAMPLE_W + 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [TAPS-1:0][SAMPLE_W-1:0]    line_q,
    input  logic                             line_vld,
    output logic [HALF-1:0][PAIR_W-1:0]      pair_q,
    output logic                             pair_vld
);

    for (genvar k = 0; k < HALF; k++) begin : g_pair
        // Register the sum of tap k and tap TAPS-1-k.
        always_ff @(posedge clk) begin
            if (!rst_n) pair_q[k] <= '0;
            else        pair_q[k] <= PAIR_W'(line_q[k]) + PAIR_W'(line_q[TAPS-1-k]);
        end
    end

    // Carry the valid flag alongside the pair sums.
    always_ff @(posedge clk) begin
        if (!rst_n) pair_vld <= 1'b0;
        else        pair_vld <= line_vld;
    end

endmodule

// File: rtl/symfir_mac_tree.sv
// Constant multipliers and adder tree. Each pair sum is scaled by its own
// elaboration-time coefficient and all products are summed at full
// precision into a registered accumulator. Unsigned arithmetic throughout.
module symfir_mac_tree #(
    parameter int HALF    = 8,
    parameter int PAIR_W  = 9,
    parameter int COEF_W  = 8,
    parameter int ACC_W   = 20,
    parameter logic [HALF*COEF_W-1:0] COEF_VEC = '0,
    localparam int PROD_W = PAIR_W + COEF_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [HALF-1:0][PAIR_W-1:0]   pair_q,
    input  logic                          pair_vld,
    output logic [ACC_W-1:0]              acc_q,
    output logic                          acc_vld
);

    logic [PROD_W-1:0] prod [HALF];
    logic [ACC_W-1:0]  acc_d;

    for (genvar k = 0; k < HALF; k++) begin : g_mul
        localparam logic [COEF_W-1:0] COEF_K = COEF_VEC[k*COEF_W +: COEF_W];
        // Multiply one pair sum by its fixed coefficient.
        always_comb prod[k] = PROD_W'(pair_q[k]) * PROD_W'(COEF_K);
    end

    // Sum all products at full width.
    always_comb begin
        acc_d = '0;
        for (int k = 0; k < HALF; k++) begin
            acc_d = acc_d + ACC_W'(prod[k]);
        end
    end

    // Register the sum and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            acc_vld <= 1'b0;
        end else begin
            acc_q   <= acc_d;
            acc_vld <= pair_vld;
        end
    end

endmodule

// File: rtl/symfir_top.sv
// Symmetric folded FIR filter, top level.
// One unsigned sample per clock in, one scaled result per clock out, three
// register stages apart. Assumes TAPS is even and that COEF_VEC and DROP
// keep the scaled sum within OUT_W bits (the bound checker watches this).
module symfir_top #(
    parameter int TAPS     = 16,
    parameter int SAMPLE_W = 8,
    parameter int OUT_W    = 10,
    parameter int COEF_W   = 8,
    parameter int DROP     = 5,
    parameter logic [(TAPS/2)*COEF_W-1:0] COEF_VEC = 64'h100C_0806_0403_0201
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    output logic                out_valid,
    output logic [OUT_W-1:0]    out_result
);

    localparam int HALF   = TAPS / 2;
    localparam int PAIR_W = SAMPLE_W + 1;
    localparam int ACC_W  = symfir_pkg::acc_width(PAIR_W, COEF_W, HALF);

    logic [TAPS-1:0][SAMPLE_W-1:0] line_q;
    logic                          line_vld;
    logic [HALF-1:0][PAIR_W-1:0]   pair_q;
    logic                          pair_vld;
    logic [ACC_W-1:0]              acc_q;
    logic                          acc_vld;

    symfir_delay_line #(
        .TAPS     (TAPS),
        .SAMPLE_W (SAMPLE_W)
    ) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (in_valid),
        .din      (in_sample),
        .line_q   (line_q),
        .line_vld (line_vld)
    );

    symfir_preadd #(
        .TAPS     (TAPS),
        .SAMPLE_W (SAMPLE_W)
    ) u_fold (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_q   (line_q),
        .line_vld (line_vld),
        .pair_q   (pair_q),
        .pair_vld (pair_vld)
    );

    symfir_mac_tree #(
        .HALF     (HALF),
        .PAIR_W   (PAIR_W),
        .COEF_W   (COEF_W),
        .ACC_W    (ACC_W),
        .COEF_VEC (COEF_VEC)
    ) u_mac (
        .clk      (clk),
        .rst_n    (rst_n),
        .pair_q   (pair_q),
        .pair_vld (pair_vld),
        .acc_q    (acc_q),
        .acc_vld  (acc_vld)
    );

    // Scale the full-precision sum by dropping DROP low bits.
    assign out_result = OUT_W'(acc_q >> DROP);
    assign out_valid  = acc_vld;

endmodule

// File: rtl/symfir_checker.sv
// Property checker for symfir_top, attached by the bind at the end of this
// file. Watches the history, the full-precision sum and the valid timing.
module symfir_checker #(
    parameter int TAPS     = 16,
    parameter int SAMPLE_W = 8,
    parameter int OUT_W    = 10,
    parameter int DROP     = 5,
    parameter int ACC_W    = 20
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic [SAMPLE_W-1:0]        in_sample,
    input logic                       out_valid,
    input logic [TAPS*SAMPLE_W-1:0]   line_q,
    input logic [ACC_W-1:0]           acc_q
);

    logic [1:0] since_rst;

    // Count edges since reset, saturating once the pipeline is filled.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1: an idle cycle leaves the history untouched.
    p_hold_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(line_q));

    // R1: a valid sample lands at tap 0 on the next edge.
    p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (line_q[SAMPLE_W-1:0] == $past(in_sample)));

    // R3: the bits above the kept result are always zero.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_q >> (DROP + OUT_W)) == '0));

    // R4: the output valid flag follows the input valid flag by three edges.
    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R6: leaving reset, the history, the sum and the valid flag are clear.
    p_reset_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && line_q == '0 && acc_q == '0));

endmodule

bind symfir_top symfir_checker #(
    .TAPS     (TAPS),
    .SAMPLE_W (SAMPLE_W),
    .OUT_W    (OUT_W),
    .DROP     (DROP),
    .ACC_W    (ACC_W)
) u_symfir_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .out_valid (out_valid),
    .line_q    (line_q),
    .acc_q     (acc_q)
);

// File: tb/test_symfir_top.sv
// Self-checking bench for symfir_top with its default configuration.
// Keeps its own sample history and a three-deep expectation pipe.
module test_symfir_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_sample = '0;
    logic       out_valid;
    logic [9:0] out_result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // R2: default coefficients c0..c7.
    int coef [8] = '{1, 2, 3, 4, 6, 8, 12, 16};
    int hist [16];
    bit pv [3];
    int pd [3];
    string tag = "R2";

    symfir_top i_symfir_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    // 50 MHz clock.
    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R3: floor of the symmetric weighted sum divided by 2^5.
    function automatic int model();
        int acc = 0;
        for (int k = 0; k < 8; k++) acc += coef[k] * (hist[k] + hist[15-k]);
        return acc >> 5;
    endfunction

    task automatic clear_model();
        for (int k = 0; k < 16; k++) hist[k] = 0;
        for (int k = 0; k < 3; k++) begin pv[k] = 1'b0; pd[k] = 0; end
    endtask

    // One clock: check the output due now, then drive the next input.
    task automatic step(input bit v, input int s);
        @(negedge clk);
        check("R4", int'(out_valid), int'(pv[2]));
        if (pv[2] && out_valid) check(tag, int'(out_result), pd[2]);
        pv[2] = pv[1]; pd[2] = pd[1];
        pv[1] = pv[0]; pd[1] = pd[0];
        if (v) begin
            for (int k = 15; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = s;
            pd[0] = model();
        end
        pv[0] = v;
        in_valid  = v;
        in_sample = 8'(s);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        clear_model();
        repeat (2) @(negedge clk);
        check("R6", int'(out_valid), 0);
        check("R6", int'(out_result), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        clear_model();
        do_reset();

        // R2: impulse of every magnitude exposes every coefficient.
        tag = "R2";
        for (int v = 0; v < 256; v++) begin
            step(1'b1, v);
            for (int z = 0; z < 15; z++) step(1'b1, 0);
        end

        // R3: sixteen or more full-scale samples give the top result 828.
        tag = "R3";
        for (int n = 0; n < 20; n++) step(1'b1, 255);
        step(1'b0, 0); step(1'b0, 0); step(1'b0, 0);
        check("R3", int'(out_result), 828);

        // R7: a step of 200 must count as a large positive value.
        tag = "R7";
        for (int n = 0; n < 16; n++) step(1'b1, 0);
        for (int n = 0; n < 20; n++) step(1'b1, 200);

        // R1: random samples with random idle gaps.
        tag = "R1";
        for (int n = 0; n < 3000; n++) begin
            step(($urandom_range(0, 2) != 0), int'($urandom_range(0, 255)));
        end

        // R5: unbroken random stream, one result per clock.
        tag = "R5";
        for (int n = 0; n < 2000; n++) step(1'b1, int'($urandom_range(0, 255)));

        // R6: reset in mid-burst, then an impulse on a cleared history.
        for (int n = 0; n < 10; n++) step(1'b1, int'($urandom_range(1, 255)));
        do_reset();
        tag = "R6";
        step(1'b1, 160);
        for (int n = 0; n < 20; n++) step(1'b1, 0);
        step(1'b0, 0); step(1'b0, 0); step(1'b0, 0); step(1'b0, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule